// File: doc/BRIEF.md
# Time-Aware Gate Schedule Sequencer

This block produces an 8-bit transmit gate mask, one bit per traffic priority, by replaying a timed list of schedule entries held in an internal fetch memory. Every entry pairs a duration, counted in wire clocks, with the mask to apply for that duration. An external periodic time generator supplies a cycle-start pulse, and on each pulse the list replays from its first entry, so the gate pattern repeats at a fixed interval. A gate interval longer than one entry can express is written as several consecutive entries that carry the same mask.

The 128-entry memory serves either as one long list or as two 64-entry halves. In split mode one half is the running (operational) schedule and the other is the standby (administrative) schedule that the host is loading. A host swap request exchanges the two roles, but only at the next cycle-start pulse. Gating runs only while the gate enable is set and the transmit arbiter is not in round-robin mode. Otherwise the mask forces every gate open. The host port and the sequencer both run on the wire clock.

Top module: `tas_gate_seq`

## Requirements
- R1: Host write port: when `wr_en` is high, `wr_data` is stored at `wr_addr` (0..127). Each entry is 22 bits wide. Bits [21:8] hold the duration count and bits [7:0] hold the gate mask.
- R2: The mask of a running entry appears on `gate_mask` for exactly its count of clocks, and then the next entry follows with no gap.
- R3: While gating is enabled, a `cycle_start` pulse restarts the list at entry 0. The mask of entry 0 appears one clock after the pulse is sampled.
- R4: The list ends at an entry whose count is zero, or after the last entry of the list. After that, `gate_mask` holds the last applied mask and `list_busy` is low until the next `cycle_start`.
- R5: When `split_mode` is 0, the list is entries 0..127. When `split_mode` is 1, the list is the 64 entries starting at address `oper_half`*64.
- R6: With `split_mode` at 1, a pulse on `swap_req` makes `oper_half` toggle at the next enabled `cycle_start` and not before. With `split_mode` at 0, `swap_req` is ignored.
- R7: When `gate_en` is 0 or `rr_mode` is 1, `gate_mask` is 8'hFF from the next clock. Sequencing then stays stopped until gating is enabled again and a `cycle_start` arrives.
- R8: A `cycle_start` that arrives while the list is still running sets `overrun`. The flag stays set until reset, and the list restarts at entry 0.
- R9: After reset, `gate_mask` is 8'hFF, `oper_half` is 0, `overrun` is 0 and `list_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host entry write strobe |
| wr_addr | input | 7 | Entry address |
| wr_data | input | 22 | Entry: count [21:8], mask [7:0] |
| split_mode | input | 1 | 1 = two 64-entry lists, 0 = one 128-entry list |
| swap_req | input | 1 | Request to exchange the running and standby halves |
| gate_en | input | 1 | Gating enable |
| rr_mode | input | 1 | Round-robin arbitration selected, which blocks gating |
| cycle_start | input | 1 | Periodic schedule restart pulse |
| gate_mask | output | 8 | Per-priority transmit gate mask |
| oper_half | output | 1 | Half currently running in split mode |
| list_busy | output | 1 | The list is being stepped |
| overrun | output | 1 | Sticky flag: restart arrived before the list ended |

## Verification
Random lists with short random counts and random masks check, clock by clock, that each entry's mask lasts exactly its count. This separates an off-by-one in the counter from an error in how entries are fetched. A directed short list with a zero terminator and two equal-mask neighbours shows how the list ends and how a long interval runs on without a break. Full 64-entry and 128-entry lists show that the end of the list is chosen by the mode. Swap requests made in the middle of a cycle, a restart that cuts a list short, and enable or arbitration-mode changes in the middle of a list show that swaps apply only at boundaries, that the overrun flag is sticky, and that the gates are forced open.

// File: rtl/tas_gsq_pkg.sv
package tas_gsq_pkg;

    localparam int unsigned DEF_ADDR_W = 7;
    localparam int unsigned DEF_CNT_W  = 14;
    localparam int unsigned DEF_MASK_W = 8;

    typedef struct packed {
        logic half;
        logic pend;
    } half_state_t;

endpackage

// File: rtl/tas_gsq_fetch_mem.sv
module tas_gsq_fetch_mem #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 22
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    // plain storage array: written by the host, read combinationally
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/tas_gsq_half_ctrl.sv
module tas_gsq_half_ctrl
    import tas_gsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic split_mode,
    input  logic swap_req,
    input  logic restart,
    output logic half_q_o,
    output logic half_nx_o
);
    half_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        half_nx_o = st_q.half;
        if (restart && split_mode && st_q.pend) begin
            half_nx_o = ~st_q.half;
        end
        if (restart) begin
            st_d.half = half_nx_o;
            st_d.pend = 1'b0;
        end
        // a request in the restart cycle waits for the following boundary
        if (swap_req && split_mode) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_q_o = st_q.half;

endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
    import tas_gsq_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned MASK_W = DEF_MASK_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W+MASK_W-1:0]   wr_data,
    input  logic                      split_mode,
    input  logic                      swap_req,
    input  logic                      gate_en,
    input  logic                      rr_mode,
    input  logic                      cycle_start,
    output logic [MASK_W-1:0]         gate_mask,
    output logic                      oper_half,
    output logic                      list_busy,
    output logic                      overrun
);
    localparam int unsigned ENTRY_W  = CNT_W + MASK_W;
    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam int unsigned HALF_LEN = DEPTH / 2;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [CNT_W-1:0]  remain;
        logic [ADDR_W-1:0] idx;
        logic              running;
        logic              overrun;
    } seq_t;

    seq_t st_d, st_q;

    logic              gating_ok;
    logic              restart;
    logic              half_q, half_nx, half_sel;
    logic [ADDR_W-1:0] idx_sel;
    logic [ADDR_W-1:0] rd_addr;
    logic [ENTRY_W-1:0] rd_data;
    logic [CNT_W-1:0]  rd_cnt;
    logic [MASK_W-1:0] rd_mask;
    logic              at_list_end;
    logic [CNT_W-1:0]  remain_q;
    logic [ADDR_W-1:0] idx_q;

    assign gating_ok = gate_en & ~rr_mode;
    assign restart   = gating_ok & cycle_start;

    tas_gsq_half_ctrl u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_mode (split_mode),
        .swap_req   (swap_req),
        .restart    (restart),
        .half_q_o   (half_q),
        .half_nx_o  (half_nx)
    );

    // address of the entry to load: entry 0 on restart, else the next one
    assign half_sel = restart ? half_nx : half_q;
    assign idx_sel  = restart ? '0 : (st_q.idx + ADDR_W'(1));
    assign rd_addr  = split_mode ? {half_sel, idx_sel[ADDR_W-2:0]} : idx_sel;

    tas_gsq_fetch_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (ENTRY_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign rd_cnt  = rd_data[ENTRY_W-1:MASK_W];
    assign rd_mask = rd_data[MASK_W-1:0];

    assign at_list_end = split_mode ? (st_q.idx == ADDR_W'(HALF_LEN - 1))
                                    : (st_q.idx == ADDR_W'(DEPTH - 1));

    always_comb begin
        st_d = st_q;
        if (!gating_ok) begin
            st_d.mask    = '1;
            st_d.remain  = '0;
            st_d.idx     = '0;
            st_d.running = 1'b0;
        end else if (cycle_start) begin
            if (st_q.running) begin
                st_d.overrun = 1'b1;
            end
            st_d.idx = '0;
            if (rd_cnt != '0) begin
                st_d.mask    = rd_mask;
                st_d.remain  = rd_cnt;
                st_d.running = 1'b1;
            end else begin
                st_d.remain  = '0;
                st_d.running = 1'b0;
            end
        end else if (st_q.running) begin
            if (st_q.remain > CNT_W'(1)) begin
                st_d.remain = st_q.remain - CNT_W'(1);
            end else if (at_list_end) begin
                st_d.remain  = '0;
                st_d.running = 1'b0;
            end else begin
                st_d.idx = idx_sel;
                if (rd_cnt != '0) begin
                    st_d.mask   = rd_mask;
                    st_d.remain = rd_cnt;
                end else begin
                    st_d.remain  = '0;
                    st_d.running = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mask    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_mask = st_q.mask;
    assign oper_half = half_q;
    assign list_busy = st_q.running;
    assign overrun   = st_q.overrun;
    assign remain_q  = st_q.remain;
    assign idx_q     = st_q.idx;

endmodule

// File: rtl/tas_gate_seq_chk.sv
module tas_gate_seq_chk #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned CNT_W  = 14,
    parameter int unsigned MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic              rr_mode,
    input logic              cycle_start,
    input logic              split_mode,
    input logic [MASK_W-1:0] gate_mask,
    input logic              oper_half,
    input logic              overrun,
    input logic [CNT_W-1:0]  remain_q,
    input logic [ADDR_W-1:0] idx_q
);
    AST_GATES_OPEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en || rr_mode) |=> (gate_mask == '1)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8

    AST_HALF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(oper_half)); // R6

    AST_SINGLE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |=> $stable(oper_half)); // R5

    AST_MASK_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !rr_mode && !cycle_start && remain_q > CNT_W'(1))
        |=> $stable(gate_mask)); // R2

    AST_RESTART_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !rr_mode && cycle_start) |=> (idx_q == '0)); // R3

endmodule

bind tas_gate_seq tas_gate_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MASK_W (MASK_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_en     (gate_en),
    .rr_mode     (rr_mode),
    .cycle_start (cycle_start),
    .split_mode  (split_mode),
    .gate_mask   (gate_mask),
    .oper_half   (oper_half),
    .overrun     (overrun),
    .remain_q    (remain_q),
    .idx_q       (idx_q)
);

// File: tb/tas_gate_seq_tb.sv
module tas_gate_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic        split_mode = 1'b0;
    logic        swap_req = 1'b0;
    logic        gate_en = 1'b0;
    logic        rr_mode = 1'b0;
    logic        cycle_start = 1'b0;
    logic [7:0]  gate_mask;
    logic        oper_half;
    logic        list_busy;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [21:0] shadow [128];
    logic [7:0]  last_mask = 8'hFF;

    always #2 clk = ~clk;

    tas_gate_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .split_mode  (split_mode),
        .swap_req    (swap_req),
        .gate_en     (gate_en),
        .rr_mode     (rr_mode),
        .cycle_start (cycle_start),
        .gate_mask   (gate_mask),
        .oper_half   (oper_half),
        .list_busy   (list_busy),
        .overrun     (overrun)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            report();
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int cnt, int m);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[6:0];
        wr_data = {cnt[13:0], m[7:0]};
        shadow[a] = {cnt[13:0], m[7:0]};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected mask t clocks after the first mask appears
    function automatic logic [7:0] exp_mask(int base, int len, int t, logic [7:0] prev);
        int rem = t;
        logic [7:0] p = prev;
        for (int i = 0; i < len; i++) begin
            int c = int'(shadow[base+i][21:8]);
            if (c == 0) return p;
            if (rem < c) return shadow[base+i][7:0];
            rem -= c;
            p = shadow[base+i][7:0];
        end
        return p;
    endfunction

    function automatic int list_cycles(int base, int len);
        int s = 0;
        for (int i = 0; i < len; i++) begin
            int c = int'(shadow[base+i][21:8]);
            if (c == 0) return s;
            s += c;
        end
        return s;
    endfunction

    task automatic run_cycle(int base, int len, int n, string req);
        logic [7:0] e;
        @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        for (int t = 0; t < n; t++) begin
            e = exp_mask(base, len, t, last_mask);
            chk(req, gate_mask, e);
            if (t < n - 1) @(negedge clk);
        end
        last_mask = exp_mask(base, len, n, last_mask);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 mask", gate_mask, 8'hFF);
        chk("R9 half", oper_half, 0);
        chk("R9 overrun", overrun, 0);
        chk("R9 busy", list_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 single 128-entry list, random contents, ends at the last entry (R4)
        for (int i = 0; i < 128; i++) wr(i, 1 + ($urandom % 3), $urandom % 256);
        gate_en = 1'b1;
        run_cycle(0, 128, list_cycles(0, 128) + 3, "R2 single list");
        chk("R4 busy after end", list_busy, 0);
        run_cycle(0, 128, list_cycles(0, 128) + 2, "R3 repeat single list");

        // split mode: directed half 0 with equal neighbours and a terminator
        split_mode = 1'b1;
        wr(0, 3, 8'hA5); wr(1, 4, 8'hA5); wr(2, 2, 8'h3C);
        wr(3, 1, 8'h0F); wr(4, 2, 8'hC3); wr(5, 0, 8'h00);
        for (int i = 64; i < 128; i++) wr(i, 1 + ($urandom % 2), $urandom % 256);
        run_cycle(0, 64, list_cycles(0, 64) + 4, "R4 terminated half0");
        chk("R4 hold after terminator", gate_mask, 8'hC3);
        chk("R4 busy low", list_busy, 0);
        chk("R5 half before swap", oper_half, 0);

        // R6 swap request waits for the boundary
        @(negedge clk);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R6 no early swap", oper_half, 0);
        end
        run_cycle(64, 64, list_cycles(64, 64) + 3, "R5 half1 after swap");
        chk("R6 half swapped", oper_half, 1);
        chk("R8 no overrun yet", overrun, 0);

        // R8 restart before list end
        run_cycle(64, 64, 5, "R8 partial list");
        run_cycle(64, 64, list_cycles(64, 64) + 2, "R8 restarted list");
        chk("R8 overrun set", overrun, 1);
        run_cycle(64, 64, 3, "R8 again");
        chk("R8 overrun sticky", overrun, 1);

        // R7 round-robin forces gates open mid-list
        rr_mode = 1'b1;
        @(negedge clk);
        chk("R7 rr open", gate_mask, 8'hFF);
        @(negedge clk); cycle_start = 1'b1;
        @(negedge clk); cycle_start = 0;
        repeat (3) begin
            @(negedge clk);
            chk("R7 rr ignores pulse", gate_mask, 8'hFF);
        end
        rr_mode = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R7 waits for pulse", gate_mask, 8'hFF);
        end
        last_mask = 8'hFF;
        run_cycle(64, 64, 4, "R7 resume");
        gate_en = 1'b0;
        @(negedge clk);
        chk("R7 enable low open", gate_mask, 8'hFF);
        chk("R7 busy low", list_busy, 0);
        gate_en = 1'b1;

        // R6 swap ignored in single mode
        split_mode = 1'b0;
        @(negedge clk);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        last_mask = 8'hFF;
        run_cycle(0, 128, 12, "R5 single list again");
        chk("R6 single ignores swap", oper_half, 1);

        // back to split: no stale request may flip the half
        split_mode = 1'b1;
        run_cycle(64, 64, list_cycles(64, 64) + 2, "R6 no stale swap");
        chk("R6 half kept", oper_half, 1);

        report();
    end

endmodule